// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block produces the instruction fetch address for a 32-bit processor that has a single branch delay slot. It keeps two registers: the address of the instruction in flight now and the address that will follow it. Every clock is one instruction step. On each step the following address moves into the current one. The new following address is then either the sequential one, a relative branch target, an absolute jump target, a register-held address or the fixed trap vector, whichever the step selects.

The decoder drives a flow kind, the branch outcome, the 16-bit offset, the 26-bit jump field, the register jump address and a trap request. All of these describe the instruction at `fetchPc`. A "likely" conditional branch that is not taken cancels the instruction in its delay slot. A trap does three things: it records a tagged return address, it sends the flow to the vector and it cancels the instruction that follows. The block also provides the link address for call instructions, and a strobe that tells the register file to drop the trapping instruction's write-back.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted and directly after it, `fetchPc` is 0, `nextPc` is 4, `annul` is 0 and `epc` is 0.
- R2: On every step, `fetchPc` takes the value `nextPc` held before the edge. If nothing redirects the step, `nextPc` becomes its old value plus 4.
- R3: For flow kind 1 (conditional branch) or 2 (likely branch) with `brTaken` high, `nextPc` becomes old `nextPc` + (sign-extended `brImm` << 2). With `brTaken` low and kind 1, it advances by 4.
- R4: For flow kind 3 (absolute jump), `nextPc` becomes {old `nextPc`[31:28], `jmpField`, 2'b00}.
- R5: For flow kind 4 (register jump), `nextPc` becomes `jmpReg` with bits [1:0] cleared. `nextPc` bits [1:0] are always 0.
- R6: For flow kind 2 with `brTaken` low, `nextPc` advances by 4 and `annul` is high for exactly the next step. A cancelled step never sets `annul` again by itself.
- R7: While `annul` is high, the flow kind, the branch inputs and `excReq` have no effect. `nextPc` advances by 4, `wbKill` stays 0 and `epc` keeps its value.
- R8: `linkAddr` always equals `nextPc` + 4.
- R9: With `excReq` high and `annul` low, `wbKill` is high in that step. `nextPc` becomes 0x3C and `annul` is high on the following step, whatever flow kind is presented.
- R10: On a trap, `epc` is loaded with `fetchPc` + 4. Bit 1 is set when `nextPc` differed from `fetchPc` + 4 (the instruction sat in a delay slot), and bit 0 is set when `excSys` is high. Otherwise `epc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flowKind | input | 3 | 0 sequential, 1 branch, 2 likely branch, 3 absolute jump, 4 register jump |
| brTaken | input | 1 | Branch condition outcome |
| brImm | input | 16 | Branch word offset |
| jmpField | input | 26 | Absolute jump word index |
| jmpReg | input | 32 | Register jump address |
| excReq | input | 1 | Trap request for the current instruction |
| excSys | input | 1 | Trap comes from a system-call or breakpoint instruction |
| fetchPc | output | 32 | Address of the current instruction |
| nextPc | output | 32 | Address of the following instruction |
| linkAddr | output | 32 | Return address for link variants |
| annul | output | 1 | Current instruction is cancelled |
| wbKill | output | 1 | Suppress the current instruction's register write |
| epc | output | 32 | Tagged trap return address |

## Verification
`linkAddr` and `wbKill` are combinational. Each is checked one time unit after the inputs are driven, in the same step. Every registered result (`fetchPc`, `nextPc`, `annul`, `epc`) is due one edge after the step that causes it. The bench therefore drives a step on a falling edge, lets one rising edge pass, and compares at the next falling edge. There it holds a model updated only from the requirements. A single register stage sits between any input and the registered outputs, so no result is sampled earlier or later than that edge.

// File: rtl/pc_sequencer_pkg.sv
package pc_sequencer_pkg;

  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BR   = 3'd1,
    FLOW_BRL  = 3'd2,
    FLOW_JABS = 3'd3,
    FLOW_JREG = 3'd4
  } flowKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selVec;
    logic selReg;
    logic selAbs;
    logic selRel;
    logic loadEpc;
    logic epcSys;
  } pcStrobe_t;

endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_sequencer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] flowKind,
  input  logic       brTaken,
  input  logic       excReq,
  input  logic       excSys,
  output pcStrobe_t  strobe,
  output logic       annul,
  output logic       wbKill
);

  logic skipQ;
  logic live;
  logic trap;
  logic isCond;
  logic setSkip;

  assign live   = !skipQ;
  assign trap   = live && excReq;
  assign isCond = (flowKind == FLOW_BR) || (flowKind == FLOW_BRL);

  // a trap wins over any redirect of the same step
  always_comb begin
    strobe         = '0;
    strobe.selVec  = trap;
    strobe.loadEpc = trap;
    strobe.epcSys  = excSys;
    if (live && !trap) begin
      strobe.selRel = isCond && brTaken;
      strobe.selAbs = (flowKind == FLOW_JABS);
      strobe.selReg = (flowKind == FLOW_JREG);
    end
  end

  assign setSkip = trap || (live && (flowKind == FLOW_BRL) && !brTaken);

  always_ff @(posedge clk) begin
    if (!rst_n) skipQ <= 1'b0;
    else        skipQ <= setSkip;
  end

  assign annul  = skipQ;
  assign wbKill = trap;

endmodule

// File: rtl/pc_seq_path.sv
module pc_seq_path
  import pc_sequencer_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          IMM_W    = 16,
  parameter int          TGT_W    = 26,
  parameter logic [31:0] VEC_ADDR = 32'h0000_003C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pcStrobe_t         strobe,
  input  logic [IMM_W-1:0]  brImm,
  input  logic [TGT_W-1:0]  jmpField,
  input  logic [ADDR_W-1:0] jmpReg,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] linkAddr,
  output logic [ADDR_W-1:0] epc
);

  localparam int REGION_W = ADDR_W - TGT_W - 2;
  localparam int SEXT_W   = ADDR_W - IMM_W - 2;
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] VECTOR = ADDR_W'(VEC_ADDR);

  logic [ADDR_W-1:0] pcQ, nextQ, epcQ;
  logic [ADDR_W-1:0] seqNext, relNext, absNext, pickNext, alignedNext;
  logic [ADDR_W-1:0] relOffset, pcPlus;
  logic              inSlot;

  assign seqNext   = nextQ + STEP;
  // offset measured from the delay-slot address
  assign relOffset = {{SEXT_W{brImm[IMM_W-1]}}, brImm, 2'b00};
  assign relNext   = nextQ + relOffset;
  assign absNext   = {nextQ[ADDR_W-1 -: REGION_W], jmpField, 2'b00};

  always_comb begin
    if (strobe.selVec)      pickNext = VECTOR;
    else if (strobe.selReg) pickNext = jmpReg;
    else if (strobe.selAbs) pickNext = absNext;
    else if (strobe.selRel) pickNext = relNext;
    else                    pickNext = seqNext;
  end

  assign alignedNext = {pickNext[ADDR_W-1:2], 2'b00};

  assign pcPlus = pcQ + STEP;
  assign inSlot = (nextQ != pcPlus);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcQ   <= '0;
      nextQ <= STEP;
      epcQ  <= '0;
    end else begin
      pcQ   <= nextQ;
      nextQ <= alignedNext;
      if (strobe.loadEpc)
        epcQ <= {pcPlus[ADDR_W-1:2], inSlot, strobe.epcSys};
    end
  end

  assign fetchPc  = pcQ;
  assign nextPc   = nextQ;
  assign linkAddr = seqNext;
  assign epc      = epcQ;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_sequencer_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          IMM_W    = 16,
  parameter int          TGT_W    = 26,
  parameter logic [31:0] VEC_ADDR = 32'h0000_003C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        flowKind,
  input  logic              brTaken,
  input  logic [IMM_W-1:0]  brImm,
  input  logic [TGT_W-1:0]  jmpField,
  input  logic [ADDR_W-1:0] jmpReg,
  input  logic              excReq,
  input  logic              excSys,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] linkAddr,
  output logic              annul,
  output logic              wbKill,
  output logic [ADDR_W-1:0] epc
);

  pcStrobe_t strobe;

  pc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flowKind (flowKind),
    .brTaken  (brTaken),
    .excReq   (excReq),
    .excSys   (excSys),
    .strobe   (strobe),
    .annul    (annul),
    .wbKill   (wbKill)
  );

  pc_seq_path #(
    .ADDR_W   (ADDR_W),
    .IMM_W    (IMM_W),
    .TGT_W    (TGT_W),
    .VEC_ADDR (VEC_ADDR)
  ) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .brImm    (brImm),
    .jmpField (jmpField),
    .jmpReg   (jmpReg),
    .fetchPc  (fetchPc),
    .nextPc   (nextPc),
    .linkAddr (linkAddr),
    .epc      (epc)
  );

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] VEC_ADDR = 32'h0000_003C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              excReq,
  input logic [ADDR_W-1:0] fetchPc,
  input logic [ADDR_W-1:0] nextPc,
  input logic              annul,
  input logic              wbKill,
  input logic [ADDR_W-1:0] epc
);

  localparam logic [ADDR_W-1:0] VECTOR = ADDR_W'(VEC_ADDR);

  AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fetchPc == $past(nextPc)); // R2

  AST_NEXT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    nextPc[1:0] == 2'b00); // R5

  AST_ANNUL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    annul |=> !annul); // R6

  AST_ANNUL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    annul |=> nextPc == $past(nextPc) + ADDR_W'(4)); // R7

  AST_ANNUL_NO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    annul |-> !wbKill); // R7

  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (excReq && !annul) |=> (nextPc == VECTOR) && annul); // R9

  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(excReq && !annul) |=> $stable(epc)); // R10

endmodule

bind pc_sequencer pc_sequencer_chk #(
  .ADDR_W   (ADDR_W),
  .VEC_ADDR (VEC_ADDR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .excReq  (excReq),
  .fetchPc (fetchPc),
  .nextPc  (nextPc),
  .annul   (annul),
  .wbKill  (wbKill),
  .epc     (epc)
);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  flowKind = '0;
  logic        brTaken = 1'b0;
  logic [15:0] brImm = '0;
  logic [25:0] jmpField = '0;
  logic [31:0] jmpReg = '0;
  logic        excReq = 1'b0;
  logic        excSys = 1'b0;
  logic [31:0] fetchPc, nextPc, linkAddr, epc;
  logic        annul, wbKill;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  logic [31:0] mPc, mNext, mEpc;
  logic        mSkip;
  string       nextTag;

  always #2.5 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rst_n(rst_n), .flowKind(flowKind), .brTaken(brTaken),
    .brImm(brImm), .jmpField(jmpField), .jmpReg(jmpReg), .excReq(excReq),
    .excSys(excSys), .fetchPc(fetchPc), .nextPc(nextPc), .linkAddr(linkAddr),
    .annul(annul), .wbKill(wbKill), .epc(epc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkState();
    check("R2 fetchPc", fetchPc, mPc);
    check({nextTag, " nextPc"}, nextPc, mNext);
    check("R6 annul", {31'd0, annul}, {31'd0, mSkip});
    check("R10 epc", epc, mEpc);
  endtask

  // drive one step at a falling edge; compare; advance the model
  task automatic step(input logic [2:0] k, input logic t, input logic [15:0] im,
                      input logic [25:0] jf, input logic [31:0] jr,
                      input logic ex, input logic sy);
    logic [31:0] nn;
    logic        trap;
    flowKind = k; brTaken = t; brImm = im; jmpField = jf; jmpReg = jr;
    excReq = ex; excSys = sy;
    #1;
    checkState();
    trap = ex && !mSkip;
    check("R8 linkAddr", linkAddr, mNext + 32'd4);
    check(mSkip ? "R7 wbKill" : "R9 wbKill", {31'd0, wbKill}, {31'd0, trap});
    if (mSkip) begin
      nn = mNext + 32'd4; nextTag = "R7";
      mSkip = 1'b0;
    end else if (ex) begin
      mEpc = (mPc + 32'd4) | {30'd0, (mNext != mPc + 32'd4), sy};
      nn = 32'h3C; nextTag = "R9";
      mSkip = 1'b1;
    end else begin
      mSkip = 1'b0;
      nn = mNext + 32'd4; nextTag = "R2";
      if ((k == 3'd1 || k == 3'd2) && t) begin
        nn = mNext + {{14{im[15]}}, im, 2'b00}; nextTag = "R3";
      end else if (k == 3'd2) begin
        mSkip = 1'b1; nextTag = "R6";
      end else if (k == 3'd3) begin
        nn = {mNext[31:28], jf, 2'b00}; nextTag = "R4";
      end else if (k == 3'd4) begin
        nn = {jr[31:2], 2'b00}; nextTag = "R5";
      end
    end
    mPc = mNext;
    mNext = nn;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] imms [4];
    imms[0] = 16'h0003; imms[1] = 16'hFFFE; imms[2] = 16'h7FFF; imms[3] = 16'h8000;
    mPc = 32'd0; mNext = 32'd4; mEpc = 32'd0; mSkip = 1'b0; nextTag = "R1";
    repeat (4) @(posedge clk);
    // R1 during reset
    @(negedge clk);
    check("R1 fetchPc", fetchPc, 32'd0);
    check("R1 nextPc", nextPc, 32'd4);
    check("R1 annul", {31'd0, annul}, 32'd0);
    check("R1 epc", epc, 32'd0);
    rst_n = 1'b1;
    #1;
    check("R1 linkAddr", linkAddr, 32'd8);

    // directed corners
    step(3'd0, 0, 16'h0, 26'h0, 32'h0, 0, 0);               // R2 plain
    step(3'd1, 1, 16'h0010, 26'h0, 32'h0, 0, 0);            // R3 taken forward
    step(3'd0, 0, 16'h0, 26'h0, 32'h0, 1, 1);               // R10 trap in delay slot, sys
    step(3'd4, 0, 16'h0, 26'h0, 32'h1234_5677, 1, 0);       // R7 annulled: ignored
    step(3'd4, 0, 16'h0, 26'h0, 32'hABCD_EF03, 0, 0);       // R5 misaligned
    step(3'd2, 0, 16'h0040, 26'h0, 32'h0, 0, 0);            // R6 likely not taken
    step(3'd3, 0, 16'h0, 26'h3FF_FFFF, 32'h0, 1, 1);        // R7 slot cancelled
    step(3'd3, 0, 16'h0, 26'h155_5555, 32'h0, 0, 0);        // R4
    step(3'd1, 1, 16'hFFFF, 26'h0, 32'h0, 1, 0);            // R9 priority over branch
    step(3'd0, 0, 16'h0, 26'h0, 32'h0, 0, 0);
    step(3'd0, 0, 16'h0, 26'h0, 32'h0, 1, 0);               // R10 not in slot

    // sweep of all step kinds, each after a prefix step
    for (int rep = 0; rep < 4; rep++)
      for (int k = 0; k < 8; k++)
        for (int t = 0; t < 2; t++)
          for (int e = 0; e < 2; e++)
            for (int s = 0; s < 2; s++)
              for (int i = 0; i < 4; i++) begin
                step(3'(rep), rep[0], imms[(i + rep) % 4], 26'(32'h2A5_1F3 * (rep + 1)),
                     32'h4000_0000 + 32'(rep * 36), (rep == 3), 1'b0);
                step(3'(k), t[0], imms[i], 26'(32'h13579B * (i + 1)),
                     32'h8000_0001 + 32'(k * 4096 + i), e[0], s[0]);
              end

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(3'(r[2:0] % 5), r[3], 16'($urandom), 26'($urandom), $urandom,
           (r[9:4] == 6'd0), r[10]);
    end
    checkState();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule